// File: doc/BRIEF.md
# Block Protection Controller Register File

This block is the software-visible register set of a block-granular memory protection controller. A 32-bit peripheral bus reaches it with a word address, write data, an access size and separate read and write strobes. It holds a control word, a security lookup table of 32-bit words, and a one-bit interrupt with status, enable, set and clear registers. Each bit of the lookup table marks one protected memory block as secure or non-secure. The table is reached through a single data port whose index can step forward by itself.

The table index moves on by one after every full-word access to the data port and wraps at the table size. Software can therefore stream the whole table through one address. A lockdown bit in the control word freezes the control word, the table and the interrupt enable until the next reset. Byte and halfword writes are merged into the current register contents before any rule is applied. Two fault-information registers are present as zero-valued read-only placeholders. Capturing faults and filtering transactions are done elsewhere.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd`. Any read side effect, namely advancing the index, takes effect at the clock edge that ends the access.

Top module: `mpc_regfile`

## Requirements
- R1: After reset, the control word, table index, interrupt status, interrupt enable and every table word read as zero, and `irq` is low.
- R2: The control word at offset 0x00 keeps only bit 4 (security error response), bit 8 (auto-increment) and bit 31 (lockdown). All other bits read as zero. The three bits also drive `cfg_sec_resp`, `cfg_autoinc` and `cfg_lockdown`.
- R3: While lockdown is set, writes to the control word (0x00), the table data port (0x1c) and the interrupt enable (0x28) change nothing, including the index. Interrupt set and clear still work. Only reset clears lockdown.
- R4: Offset 0x10 reads the table word count parameter. Offset 0x14 reads log2(block size in bytes) minus 5.
- R5: A write to the index register at 0x18 stores the written value modulo the table word count. The index always stays below that count.
- R6: Offset 0x1c reads and writes the table word selected by the index. A full-word access to it then advances the index by one and wraps to zero after the last word.
- R7: The access size is coded as 0 for byte, 1 for halfword and 2 or 3 for word. A narrower access to 0x1c leaves the index unchanged. A narrower write places its low data bits at bit position addr[1:0]*8 within the current register value, and the other bits are kept.
- R8: Writing 1 to bit 0 of 0x34 sets the interrupt status (0x20 bit 0). Writing 1 to bit 0 of 0x24 clears it. The enable is bit 0 of 0x28. `irq` equals status AND enable and follows them from the edge at which either changes.
- R9: The fault-information registers at 0x2c and 0x30 read zero and ignore writes. Any unmapped offset reads zero and a write to it has no effect.
- R10: The twelve identification words from 0xfd0 to 0xffc read 0xA0 plus the word number k (0 to 11) in bits 7:0, and zero above that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data, low-aligned for narrow writes |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data for the addressed register |
| cfg_sec_resp | output | 1 | Security error response select |
| cfg_autoinc | output | 1 | Auto-increment flag |
| cfg_lockdown | output | 1 | Lockdown state |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The assertions assume that the bus never raises read and write in the same cycle. They also assume that each strobe marks exactly one access, so a read held high for several cycles would count as several index advances. The stimulus drives every access from a task that raises a single strobe for one cycle and clears it again, so this assumption always holds. The same tasks change inputs only on the falling edge, which keeps the properties sampled at the rising edge free of races.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  // word offsets (byte offset >> 2)
  localparam logic [9:0] W_CTRL   = 10'd0;
  localparam logic [9:0] W_NWORDS = 10'd4;
  localparam logic [9:0] W_BCFG   = 10'd5;
  localparam logic [9:0] W_IDX    = 10'd6;
  localparam logic [9:0] W_LUT    = 10'd7;
  localparam logic [9:0] W_STAT   = 10'd8;
  localparam logic [9:0] W_CLR    = 10'd9;
  localparam logic [9:0] W_EN     = 10'd10;
  localparam logic [9:0] W_INFO1  = 10'd11;
  localparam logic [9:0] W_INFO2  = 10'd12;
  localparam logic [9:0] W_SET    = 10'd13;
  localparam logic [9:0] W_ID0    = 10'h3F4;
  localparam int unsigned ID_COUNT = 12;

  localparam logic [31:0] CTRL_MASK = 32'h8000_0110;
  localparam int unsigned B_SECRESP = 4;
  localparam int unsigned B_AUTOINC = 8;
  localparam int unsigned B_LOCK    = 31;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    return 8'hA0 | {4'h0, k};
  endfunction
endpackage

// File: rtl/mpc_write_merge.sv
module mpc_write_merge
  import mpc_pkg::*;
(
  input  logic [31:0] old_val,
  input  logic [31:0] wdata,
  input  logic [1:0]  size,
  input  logic [1:0]  offs,
  output logic [31:0] merged
);
  logic [2:0] nbytes;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = 3'd1;
      SZ_HALF: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  always_comb begin
    merged = old_val;
    if (nbytes == 3'd4) begin
      merged = wdata;
    end else begin
      for (int j = 0; j < 4; j++) begin
        if (3'(j) >= {1'b0, offs} && 3'(j) < ({1'b0, offs} + nbytes)) begin
          merged[j*8 +: 8] = wdata[(j - int'(offs))*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/mpc_blk_table.sv
module mpc_blk_table #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [31:0]      idx_wdata,
  input  logic             word_wr,
  input  logic [31:0]      word_wdata,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      word_rd
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_next;
  logic [31:0]      mem_q [WORDS];

  assign idx      = idx_q;
  assign word_rd  = mem_q[idx_q];
  assign idx_next = (idx_q == IDX_W'(WORDS - 1)) ? '0 : idx_q + IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= IDX_W'(idx_wdata % 32'(WORDS));
    end else if (advance) begin
      idx_q <= idx_next;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (word_wr && idx_q == IDX_W'(g)) begin
        mem_q[g] <= word_wdata;
      end
    end
  end
endmodule

// File: rtl/mpc_irq_ctrl.sv
module mpc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic en_wr,
  input  logic en_val,
  output logic stat,
  output logic en,
  output logic irq
);
  logic stat_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_req)      stat_q <= 1'b1;
      else if (clr_req) stat_q <= 1'b0;
      if (en_wr)        en_q   <= en_val;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = stat_q & en_q;
endmodule

// File: rtl/mpc_regfile.sv
module mpc_regfile
  import mpc_pkg::*;
#(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned BLK_LOG2 = 7,
  localparam int unsigned IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_size,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        cfg_sec_resp,
  output logic        cfg_autoinc,
  output logic        cfg_lockdown,
  output logic        irq
);
  logic [9:0]       waddr;
  logic             full_acc;
  logic [31:0]      ctrl_q;
  logic [31:0]      old_val;
  logic [31:0]      merged;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0]      tbl_word;
  logic             irq_stat, irq_en;
  logic             locked;
  logic             hit_ctrl, hit_idx, hit_lut, hit_en, hit_set, hit_clr;
  logic             lut_wr_ok, lut_adv;
  logic [9:0]       id_k;

  assign waddr    = bus_addr[11:2];
  assign full_acc = bus_size[1];
  assign locked   = ctrl_q[B_LOCK];

  assign hit_ctrl = waddr == W_CTRL;
  assign hit_idx  = waddr == W_IDX;
  assign hit_lut  = waddr == W_LUT;
  assign hit_en   = waddr == W_EN;
  assign hit_set  = waddr == W_SET;
  assign hit_clr  = waddr == W_CLR;

  always_comb begin
    if (hit_ctrl)     old_val = ctrl_q;
    else if (hit_idx) old_val = 32'(tbl_idx);
    else if (hit_lut) old_val = tbl_word;
    else              old_val = '0;
  end

  mpc_write_merge u_merge (
    .old_val (old_val),
    .wdata   (bus_wdata),
    .size    (bus_size),
    .offs    (bus_addr[1:0]),
    .merged  (merged)
  );

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (bus_wr && hit_ctrl && !locked) begin
      ctrl_q <= merged & CTRL_MASK;
    end
  end

  assign cfg_sec_resp = ctrl_q[B_SECRESP];
  assign cfg_autoinc  = ctrl_q[B_AUTOINC];
  assign cfg_lockdown = ctrl_q[B_LOCK];

  // table
  assign lut_wr_ok = bus_wr && hit_lut && !locked;
  assign lut_adv   = full_acc && hit_lut && (bus_rd || lut_wr_ok);

  mpc_blk_table #(.WORDS(WORDS)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (bus_wr && hit_idx),
    .idx_wdata  (merged),
    .word_wr    (lut_wr_ok),
    .word_wdata (merged),
    .advance    (lut_adv),
    .idx        (tbl_idx),
    .word_rd    (tbl_word)
  );

  // interrupt
  mpc_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (bus_wr && hit_set && merged[0]),
    .clr_req (bus_wr && hit_clr && merged[0]),
    .en_wr   (bus_wr && hit_en && !locked),
    .en_val  (merged[0]),
    .stat    (irq_stat),
    .en      (irq_en),
    .irq     (irq)
  );

  // read mux
  assign id_k = waddr - W_ID0;

  always_comb begin
    bus_rdata = '0;
    case (waddr)
      W_CTRL:   bus_rdata = ctrl_q;
      W_NWORDS: bus_rdata = 32'(WORDS);
      W_BCFG:   bus_rdata = 32'(BLK_LOG2 - 5);
      W_IDX:    bus_rdata = 32'(tbl_idx);
      W_LUT:    bus_rdata = tbl_word;
      W_STAT:   bus_rdata = {31'b0, irq_stat};
      W_EN:     bus_rdata = {31'b0, irq_en};
      default: begin
        if (waddr >= W_ID0 && id_k < 10'(ID_COUNT)) begin
          bus_rdata = {24'b0, id_byte(id_k[3:0])};
        end
      end
    endcase
  end
endmodule

// File: rtl/mpc_regfile_chk.sv
module mpc_regfile_chk #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [1:0]       bus_size,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic             cfg_sec_resp,
  input logic             cfg_autoinc,
  input logic             cfg_lockdown,
  input logic             irq,
  input logic [IDX_W-1:0] idx
);
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'd0) |-> (bus_rdata & ~32'h8000_0110) == 32'h0);

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lockdown |=> cfg_lockdown);

  p_lock_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lockdown && bus_wr && bus_addr[11:2] == 10'd0) |=> $stable({cfg_sec_resp, cfg_autoinc}));

  p_lock_lut_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lockdown && bus_wr && bus_addr[11:2] == 10'd7) |=> $stable(idx));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx) < 32'(WORDS));

  p_narrow_noadv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr[11:2] == 10'd7 && !bus_size[1]) |=> $stable(idx));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h024 && bus_size[1] && bus_wdata[0]) |=> !irq);
endmodule

bind mpc_regfile mpc_regfile_chk #(.WORDS(WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_size     (bus_size),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .cfg_sec_resp (cfg_sec_resp),
  .cfg_autoinc  (cfg_autoinc),
  .cfg_lockdown (cfg_lockdown),
  .irq          (irq),
  .idx          (tbl_idx)
);

// File: tb/tb_mpc_regfile.sv
module tb_mpc_regfile;
  localparam int unsigned WORDS    = 8;
  localparam int unsigned BLK_LOG2 = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = 2'd2;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        cfg_sec_resp, cfg_autoinc, cfg_lockdown, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mpc_regfile #(.WORDS(WORDS), .BLK_LOG2(BLK_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_sec_resp(cfg_sec_resp), .cfg_autoinc(cfg_autoinc),
    .cfg_lockdown(cfg_lockdown), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(12'h000, 2'd2, v); chk("R1 ctrl", v, 32'h0);
    rd(12'h018, 2'd2, v); chk("R1 idx", v, 32'h0);
    rd(12'h020, 2'd2, v); chk("R1 stat", v, 32'h0);
    rd(12'h028, 2'd2, v); chk("R1 en", v, 32'h0);
    for (int i = 0; i < WORDS; i++) begin
      rd(12'h01c, 2'd2, v); chk("R1 table word", v, 32'h0);
    end
  endtask

  task automatic t_params();
    logic [31:0] v;
    rd(12'h010, 2'd2, v); chk("R4 word count", v, 32'(WORDS));
    rd(12'h014, 2'd2, v); chk("R4 block cfg", v, 32'(BLK_LOG2 - 5));
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(12'h000, 32'h7fff_ffff, 2'd2);
    rd(12'h000, 2'd2, v); chk("R2 ctrl mask", v, 32'h0000_0110);
    chk("R2 pins", {29'b0, cfg_sec_resp, cfg_autoinc, cfg_lockdown}, 32'h6);
    wr(12'h001, 32'h0000_0000, 2'd0);
    rd(12'h000, 2'd2, v); chk("R7 byte merge ctrl", v, 32'h0000_0010);
    wr(12'h000, 32'h0, 2'd2);
  endtask

  task automatic t_index();
    logic [31:0] v;
    wr(12'h018, 32'd11, 2'd2);
    rd(12'h018, 2'd2, v); chk("R5 idx modulo 11", v, 32'd3);
    wr(12'h018, 32'd8, 2'd2);
    rd(12'h018, 2'd2, v); chk("R5 idx modulo 8", v, 32'd0);
  endtask

  task automatic t_table();
    logic [31:0] v;
    wr(12'h018, 32'd0, 2'd2);
    for (int i = 0; i < WORDS; i++) wr(12'h01c, 32'hC0DE_0000 + 32'(i), 2'd2);
    rd(12'h018, 2'd2, v); chk("R6 idx wrapped after writes", v, 32'd0);
    for (int i = 0; i < WORDS; i++) begin
      rd(12'h01c, 2'd3, v); chk("R6 table readback", v, 32'hC0DE_0000 + 32'(i));
    end
    rd(12'h018, 2'd2, v); chk("R6 idx wrapped after reads", v, 32'd0);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    wr(12'h018, 32'd2, 2'd2);
    wr(12'h01d, 32'h0000_005A, 2'd0);
    rd(12'h018, 2'd2, v); chk("R7 narrow write keeps idx", v, 32'd2);
    rd(12'h01c, 2'd1, v); chk("R7 byte merged into word", v, 32'hC0DE_5A02);
    rd(12'h018, 2'd2, v); chk("R7 narrow read keeps idx", v, 32'd2);
    wr(12'h01e, 32'h0000_BEEF, 2'd1);
    rd(12'h01c, 2'd2, v); chk("R7 half merged into word", v, 32'hBEEF_5A02);
    rd(12'h018, 2'd2, v); chk("R6 full read advances", v, 32'd3);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(12'h028, 32'h1, 2'd2);
    chk("R8 enable only", {31'b0, irq}, 32'h0);
    wr(12'h034, 32'h2, 2'd2);
    rd(12'h020, 2'd2, v); chk("R8 set without bit0", v, 32'h0);
    wr(12'h034, 32'h1, 2'd2);
    chk("R8 irq after set", {31'b0, irq}, 32'h1);
    rd(12'h020, 2'd2, v); chk("R8 stat set", v, 32'h1);
    wr(12'h028, 32'h0, 2'd2);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h028, 32'h1, 2'd2);
    chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
    wr(12'h024, 32'h1, 2'd2);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    rd(12'h020, 2'd2, v); chk("R8 stat cleared", v, 32'h0);
  endtask

  task automatic t_info();
    logic [31:0] v;
    wr(12'h02c, 32'hFFFF_FFFF, 2'd2);
    wr(12'h030, 32'hFFFF_FFFF, 2'd2);
    rd(12'h02c, 2'd2, v); chk("R9 info1", v, 32'h0);
    rd(12'h030, 2'd2, v); chk("R9 info2", v, 32'h0);
    wr(12'h040, 32'hFFFF_FFFF, 2'd2);
    rd(12'h040, 2'd2, v); chk("R9 unmapped read", v, 32'h0);
    rd(12'h000, 2'd2, v); chk("R9 unmapped write no effect", v, 32'h0);
  endtask

  task automatic t_id();
    logic [31:0] v;
    for (int k = 0; k < 12; k++) begin
      rd(12'hfd0 + 12'(4 * k), 2'd2, v); chk("R10 id word", v, 32'h0A0 + 32'(k));
    end
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(12'h018, 32'd5, 2'd2);
    wr(12'h000, 32'h8000_0010, 2'd2);
    rd(12'h000, 2'd2, v); chk("R3 lock set", v, 32'h8000_0010);
    wr(12'h000, 32'h0000_0100, 2'd2);
    rd(12'h000, 2'd2, v); chk("R3 ctrl frozen", v, 32'h8000_0010);
    wr(12'h01c, 32'h1234_5678, 2'd2);
    rd(12'h018, 2'd2, v); chk("R3 locked lut write keeps idx", v, 32'd5);
    rd(12'h01c, 2'd0, v); chk("R3 table frozen", v, 32'hC0DE_0005);
    wr(12'h028, 32'h0, 2'd2);
    rd(12'h028, 2'd2, v); chk("R3 enable frozen", v, 32'h1);
    wr(12'h034, 32'h1, 2'd2);
    chk("R3 set still works", {31'b0, irq}, 32'h1);
    wr(12'h024, 32'h1, 2'd2);
    chk("R3 clear still works", {31'b0, irq}, 32'h0);
    do_reset();
    chk("R3 reset clears lock", {31'b0, cfg_lockdown}, 32'h0);
    t_reset();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_params();
    t_ctrl();
    t_index();
    t_table();
    t_narrow();
    t_irq();
    t_info();
    t_id();
    t_lock();
    finish_run();
  end
endmodule